// File: doc/BRIEF.md
# Packed Byte Permute Unit

This block rearranges the bytes of a 128-bit vector in one of two ways, chosen by an opcode. In shuffle mode, every result lane reads its own control byte from operand B: a set top bit zeroes the lane, and otherwise a small index picks any byte of operand A to copy there. In align mode, operand A is placed above operand B to form a double-width value. That pair is shifted right by a whole number of bytes, and the low half is kept. This extracts a byte window that straddles the two operands.

A half-width mode works on the low 64 bits only, and the upper 64 result bits are zero in that mode. Each accepted operation produces a registered result one cycle later, together with its own valid flag. A new operation may be issued every cycle.

Top module: `byte_permute_unit`

## Requirements
- R1: In shuffle mode (`op_i`=0), a result lane whose control byte (byte i of `opb_i`, at bits [8i+7:8i]) has bit 7 set is zero.
- R2: In shuffle mode at full width (`half_i`=0), a lane whose control bit 7 is clear takes byte k of `opa_i`, where k is control bits [3:0].
- R3: In shuffle mode, control bits [6:4] have no effect on the result.
- R4: In shuffle mode at half width (`half_i`=1), lanes 0..7 use only control bits [2:0] to pick among bytes 0..7 of `opa_i`. Result bits [127:64] are zero.
- R5: In align mode (`op_i`=1) at full width, the result is the low 128 bits of {`opa_i`,`opb_i`} shifted right by 8×`shift_i` bits, for counts 0..31. Counts 16..31 yield bytes of `opa_i` only, with zero fill above them.
- R6: In align mode at full width, a count of 32 or more gives an all-zero result.
- R7: In align mode at half width, result bits [63:0] are the low 64 bits of {`opa_i`[63:0],`opb_i`[63:0]} shifted right by `shift_i` bytes. The result is zero for counts of 16 or more, and result bits [127:64] are zero.
- R8: `valid_o` and `result_o` follow an operation presented with `valid_i` by exactly one clock. Operations on consecutive cycles each produce their own result.
- R9: While `valid_i` is low, `result_o` keeps its last value.
- R10: After reset, `valid_o` is 0 and `result_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 1 | 0 = shuffle, 1 = align |
| half_i | input | 1 | 1 = operate on the low 64 bits only |
| opa_i | input | 128 | Shuffle source / upper align operand |
| opb_i | input | 128 | Shuffle control / lower align operand |
| shift_i | input | 6 | Align byte count |
| valid_o | output | 1 | Result valid |
| result_o | output | 128 | Registered result |

## Verification
The assertions read the inputs one cycle in the past. They therefore assume that `op_i`, `half_i`, the operands and `shift_i` are known, two-state values whenever `valid_i` is high, and that `valid_i` itself is never unknown after reset. The bench drives every input from zeroed values at time zero. It changes the inputs only at the falling edge, and it deasserts `valid_i` between the isolated operations, so each sampled result maps to a single cycle of stimulus. The sweeps cover every control byte value in both widths and every shift count from 0 to 63, including the counts that the assertions treat as zero-producing.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic {
    OP_SHUF  = 1'b0,
    OP_ALIGN = 1'b1
  } bpu_op_e;
endpackage

// File: rtl/bpu_shuffle_lane.sv
module bpu_shuffle_lane #(
  parameter int LANES  = 16,
  parameter int BYTE_W = 8
) (
  input  logic [LANES*BYTE_W-1:0] src_i,
  input  logic [$clog2(LANES)-1:0] idx_i,
  input  logic                     zero_i,
  input  logic                     half_i,
  output logic [BYTE_W-1:0]        byte_o
);
  localparam int IDX_W = $clog2(LANES);

  logic [IDX_W-1:0] idx_sel;

  // half width reaches only the low half of the source
  assign idx_sel = half_i ? {1'b0, idx_i[IDX_W-2:0]} : idx_i;
  assign byte_o  = zero_i ? '0 : src_i[int'(idx_sel)*BYTE_W +: BYTE_W];
endmodule

// File: rtl/bpu_align.sv
module bpu_align #(
  parameter int LANES   = 16,
  parameter int BYTE_W  = 8,
  parameter int SHIFT_W = 6
) (
  input  logic [LANES*BYTE_W-1:0] hi_i,
  input  logic [LANES*BYTE_W-1:0] lo_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  input  logic                    half_i,
  output logic [LANES*BYTE_W-1:0] win_o
);
  localparam int CAT_N  = 2 * LANES;
  localparam int HALF_N = LANES / 2;
  localparam int CAT_W  = $clog2(CAT_N);

  logic [BYTE_W-1:0] cat [CAT_N];

  // half width packs {hi.low, lo.low} into the first LANES slots
  for (genvar j = 0; j < CAT_N; j++) begin : g_cat
    if (j < HALF_N) begin : g_lo
      assign cat[j] = lo_i[j*BYTE_W +: BYTE_W];
    end else if (j < LANES) begin : g_mid
      assign cat[j] = half_i ? hi_i[(j-HALF_N)*BYTE_W +: BYTE_W]
                             : lo_i[j*BYTE_W +: BYTE_W];
    end else begin : g_hi
      assign cat[j] = half_i ? '0 : hi_i[(j-LANES)*BYTE_W +: BYTE_W];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_win
    int pos;
    int limit;
    always_comb begin
      pos   = i + int'(shift_i);
      limit = half_i ? LANES : CAT_N;
    end
    if (i < HALF_N) begin : g_low
      assign win_o[i*BYTE_W +: BYTE_W] = (pos < limit) ? cat[pos[CAT_W-1:0]] : '0;
    end else begin : g_up
      assign win_o[i*BYTE_W +: BYTE_W] =
        (!half_i && pos < limit) ? cat[pos[CAT_W-1:0]] : '0;
    end
  end
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit #(
  parameter int LANES   = 16,
  parameter int BYTE_W  = 8,
  parameter int SHIFT_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    op_i,
  input  logic                    half_i,
  input  logic [LANES*BYTE_W-1:0] opa_i,
  input  logic [LANES*BYTE_W-1:0] opb_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  output logic                    valid_o,
  output logic [LANES*BYTE_W-1:0] result_o
);
  import bpu_pkg::*;

  localparam int VEC_W  = LANES * BYTE_W;
  localparam int IDX_W  = $clog2(LANES);
  localparam int HALF_N = LANES / 2;

  logic [VEC_W-1:0] shuf_w;
  logic [VEC_W-1:0] align_w;
  logic [VEC_W-1:0] next_w;
  logic [VEC_W-1:0] result_q;
  logic             valid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_zero;
    if (g < HALF_N) begin : g_lo
      assign lane_zero = opb_i[g*BYTE_W + BYTE_W-1];
    end else begin : g_hi
      assign lane_zero = opb_i[g*BYTE_W + BYTE_W-1] | half_i;
    end
    bpu_shuffle_lane #(.LANES(LANES), .BYTE_W(BYTE_W)) u_lane (
      .src_i  (opa_i),
      .idx_i  (opb_i[g*BYTE_W +: IDX_W]),
      .zero_i (lane_zero),
      .half_i (half_i),
      .byte_o (shuf_w[g*BYTE_W +: BYTE_W])
    );
  end

  bpu_align #(.LANES(LANES), .BYTE_W(BYTE_W), .SHIFT_W(SHIFT_W)) u_align (
    .hi_i    (opa_i),
    .lo_i    (opb_i),
    .shift_i (shift_i),
    .half_i  (half_i),
    .win_o   (align_w)
  );

  assign next_w = (bpu_op_e'(op_i) == OP_ALIGN) ? align_w : shuf_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) result_q <= next_w;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = result_q;
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker #(
  parameter int LANES   = 16,
  parameter int BYTE_W  = 8,
  parameter int SHIFT_W = 6
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    op_i,
  input logic                    half_i,
  input logic [LANES*BYTE_W-1:0] opb_i,
  input logic [SHIFT_W-1:0]      shift_i,
  input logic                    valid_o,
  input logic [LANES*BYTE_W-1:0] result_o
);
  localparam int VEC_W = LANES * BYTE_W;
  localparam int HW    = VEC_W / 2;

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R8
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R9
  AST_SHUF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !op_i && opb_i[BYTE_W-1] |=> result_o[BYTE_W-1:0] == '0); // R1
  AST_HALF_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && half_i |=> result_o[VEC_W-1:HW] == '0); // R4
  AST_ALIGN_FAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i && !half_i && shift_i >= SHIFT_W'(2*LANES) |=> result_o == '0); // R6
  AST_ALIGN_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i && !half_i && shift_i == '0 |=> result_o == $past(opb_i)); // R5
endmodule

bind byte_permute_unit bpu_checker #(
  .LANES(LANES), .BYTE_W(BYTE_W), .SHIFT_W(SHIFT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .half_i   (half_i),
  .opb_i    (opb_i),
  .shift_i  (shift_i),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/byte_permute_unit_bench.sv
`timescale 1ns/1ps
module byte_permute_unit_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         op_i = 1'b0;
  logic         half_i = 1'b0;
  logic [127:0] opa_i = '0;
  logic [127:0] opb_i = '0;
  logic [5:0]   shift_i = '0;
  logic         valid_o;
  logic [127:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  byte_permute_unit u_byte_permute_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .half_i(half_i), .opa_i(opa_i), .opb_i(opb_i), .shift_i(shift_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [127:0] exp_shuf(logic [127:0] a, logic [127:0] b, logic h);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] c = b[8*i +: 8];
      if (c[7] || (h && i >= 8)) r[8*i +: 8] = 8'h00;
      else if (h) r[8*i +: 8] = a[8*int'(c[2:0]) +: 8];
      else r[8*i +: 8] = a[8*int'(c[3:0]) +: 8];
    end
    return r;
  endfunction

  function automatic logic [127:0] exp_align(logic [127:0] a, logic [127:0] b, int n, logic h);
    logic [127:0] r = '0;
    logic [7:0] cat [32];
    int span = h ? 16 : 32;
    int outs = h ? 8 : 16;
    for (int j = 0; j < 32; j++) cat[j] = 8'h00;
    for (int j = 0; j < span; j++)
      if (j < span/2) cat[j] = b[8*j +: 8];
      else cat[j] = a[8*(j-span/2) +: 8];
    for (int i = 0; i < outs; i++)
      if (i + n < span) r[8*i +: 8] = cat[i+n];
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic op, logic h, logic [127:0] a, logic [127:0] b, logic [5:0] s);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; half_i = h; opa_i = a; opb_i = b; shift_i = s;
  endtask

  task automatic run(string tag, logic op, logic h, logic [127:0] a, logic [127:0] b, logic [5:0] s);
    logic [127:0] e = op ? exp_align(a, b, int'(s), h) : exp_shuf(a, b, h);
    drive(op, h, a, b, s);
    @(negedge clk_i);
    valid_i = 1'b0;
    check(tag, result_o, e);
    check(tag, {127'b0, valid_o}, 128'd1);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] a, b, keep, e1, e2;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10", {127'b0, valid_o}, 128'd0);
    check("R10", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10", {127'b0, valid_o}, 128'd0);

    // R1 all lanes cleared
    run("R1", 1'b0, 1'b0, rnd128(), {16{8'h80}}, 6'd0);
    // R3 reserved bits set: identity permutation
    for (int i = 0; i < 16; i++) b[8*i +: 8] = 8'h70 | 8'(i);
    a = rnd128();
    drive(1'b0, 1'b0, a, b, 6'd0);
    @(negedge clk_i); valid_i = 1'b0;
    check("R3", result_o, a);

    // R2 / R4 sweep of every control byte value in both widths
    for (int c = 0; c < 256; c++) begin
      for (int i = 0; i < 16; i++) b[8*i +: 8] = 8'((c + 37*i) & 8'hFF);
      b[7:0] = 8'(c);
      for (int k = 0; k < 16; k++) a[8*k +: 8] = 8'(k*17 + c);
      run("R2", 1'b0, 1'b0, a, b, 6'd0);
      run("R4", 1'b0, 1'b1, a, b, 6'd0);
    end

    // R5 / R6 / R7 every shift count
    for (int n = 0; n < 64; n++) begin
      a = rnd128(); b = rnd128();
      run(n < 32 ? "R5" : "R6", 1'b1, 1'b0, a, b, 6'(n));
      run("R7", 1'b1, 1'b1, a, b, 6'(n));
    end

    // R8 back to back
    a = rnd128(); b = rnd128();
    e1 = exp_align(a, b, 5, 1'b0);
    e2 = exp_shuf(b, a, 1'b0);
    drive(1'b1, 1'b0, a, b, 6'd5);
    drive(1'b0, 1'b0, b, a, 6'd0);
    check("R8", result_o, e1);
    @(negedge clk_i); valid_i = 1'b0;
    check("R8", result_o, e2);
    check("R8", {127'b0, valid_o}, 128'd1);
    @(negedge clk_i);
    check("R8", {127'b0, valid_o}, 128'd0);

    // R9 hold while idle with changing inputs
    keep = result_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      opa_i = rnd128(); opb_i = rnd128(); op_i = 1'(i); shift_i = 6'(i);
    end
    @(negedge clk_i);
    check("R9", result_o, keep);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule